// File: doc/BRIEF.md
# Dual-Channel Timer/Counter Unit

This block holds two independent timer/counter channels that sit beside a small microcontroller core. Each channel has a 4-bit configuration nibble and a run bit. Together they choose the count width and the reload behaviour, whether the channel counts internal machine-cycle ticks or falling edges on an external count pin, and whether an external interrupt pin gates counting.

When a channel's counter rolls over from all ones to zero, the channel raises an overflow flag. That flag stays set until the interrupt controller acknowledges it, or until software rewrites the control register. In split mode, channel 0 becomes two separate 8-bit timers, and the second of these borrows channel 1's run bit and flag.

A flat register port gives write access and combinational read access to one configuration register, one control register and four count bytes. The machine-cycle divider lives outside the block and supplies a one-cycle tick-enable.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register reads 0x00 and both overflow flags are low.
- R2: Addresses are 0 configuration, 1 control, 2 and 3 channel 0 low and high count, 4 and 5 channel 1 low and high count. Other addresses read 0x00. Control bits are: bit 7 channel 1 flag, bit 6 channel 1 run, bit 5 channel 0 flag, bit 4 channel 0 run, bits 3..0 read 0. Every register can be written at any time. A write to a count byte of a channel takes priority over that channel's counting in the same cycle, and that channel does not count in that cycle.
- R3: Configuration bits 3..0 belong to channel 0 and bits 7..4 to channel 1. Within each nibble: bit 3 gate enable, bit 2 external-count select, bits 1..0 mode.
- R4: Mode 00 is a 13-bit counter. Low byte bits 4..0 count and carry into the 8-bit high byte. Low byte bits 7..5 hold their value. Overflow occurs when all 13 bits roll to zero.
- R5: Mode 01 is a 16-bit counter {high, low} that overflows from 0xFFFF to 0x0000.
- R6: Mode 10 counts the low byte only. When the low byte would roll over from 0xFF, it is loaded from the high byte instead and the channel overflows. The high byte is unchanged.
- R7: Mode 11 on channel 0 splits it. The low byte counts under channel 0's controls and overflow sets the channel 0 flag. The high byte counts machine ticks whenever the channel 1 run bit is set, ignoring gate and count select, and its overflow sets the channel 1 flag. While channel 0 is split, channel 1's own overflows do not set its flag. Channel 1 in mode 11 holds its count.
- R8: With gate enable 1, a channel counts only while its run bit is 1 and its gate pin is high. With gate enable 0, the gate pin has no effect.
- R9: With external-count select 0, one count is made per tick-enable cycle. With select 1, the count pin is sampled on tick-enable cycles, and one count is made on a tick whose sample is 0 when the previous sample was 1. Pin changes between ticks are not seen.
- R10: On overflow, the channel's flag goes high on the next clock, appears on `ovf_flag_o` and in the control register, and stays high until it is cleared.
- R11: A one-cycle acknowledge clears the flag. An overflow in the same cycle as an acknowledge leaves the flag set. A control-register write in that cycle sets the flag to the written value, overriding both.
- R12: With its run bit 0, a channel's count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle machine-tick enable |
| cnt_pin_i | input | 2 | External count pins, index = channel |
| gate_pin_i | input | 2 | External gate pins, index = channel |
| ack_i | input | 2 | Overflow acknowledge, index = channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Combinational read data |
| ovf_flag_o | output | 2 | Overflow flags, index = channel |

## Verification
A wrong count shows on the read port one clock after the tick that caused it, because every count byte can be read combinationally at any time. A wrong mode decode or carry path usually stays hidden until a rollover boundary. For that reason, the tests preload counts just below 0x1F, 0xFF and 0xFFFF, so that a fault appears within one or two ticks as a wrong reload value, a wrong carry, or a flag at the wrong time. A wrong flag priority appears on `ovf_flag_o` in the cycle right after the conflicting acknowledge, write or overflow.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

    localparam int BYTE_W  = 8;
    localparam int LOW13_W = 5;
    localparam int ADDR_W  = 3;

    typedef enum logic [1:0] {
        MODE_13B    = 2'b00,
        MODE_16B    = 2'b01,
        MODE_RELOAD = 2'b10,
        MODE_SPLIT  = 2'b11
    } tmode_e;

    typedef struct packed {
        logic   gate;
        logic   ext;
        tmode_e mode;
    } chcfg_t;

    localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT0 = 3'd2;

endpackage

// File: rtl/tmr_edge_smp.sv
module tmr_edge_smp #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] fall_o
);

    logic [N-1:0] smp_d, smp_q;

    always_comb begin
        smp_d  = tick_i ? pin_i : smp_q;
        fall_o = {N{tick_i}} & smp_q & ~pin_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R9
        fall_then_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fall_o[g] |=> !smp_q[g]);
        // R9
        no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !tick_i |=> smp_q[g] == $past(smp_q[g]));
    end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pair_pkg::*;
#(
    parameter int DW       = BYTE_W,
    parameter int LW       = LOW13_W,
    parameter bit SPLIT_OK = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tmode_e        mode_i,
    input  logic          inc_i,
    input  logic          inc_hi_i,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] lo_o,
    output logic [DW-1:0] hi_o,
    output logic          ovf_o,
    output logic          ovf_hi_o
);

    localparam logic [LW-1:0]   L_ONE = LW'(1);
    localparam logic [DW-1:0]   B_ONE = DW'(1);
    localparam logic [2*DW-1:0] W_ONE = (2*DW)'(1);

    typedef struct packed {
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
    } cnt_t;

    cnt_t st_d, st_q;
    logic [2*DW-1:0] cat_sum;

    assign cat_sum = {st_q.hi, st_q.lo} + W_ONE;

    always_comb begin
        st_d     = st_q;
        ovf_o    = 1'b0;
        ovf_hi_o = 1'b0;
        if (wr_lo_i || wr_hi_i) begin
            if (wr_lo_i) st_d.lo = wdata_i;
            if (wr_hi_i) st_d.hi = wdata_i;
        end else begin
            case (mode_i)
                MODE_13B: begin
                    if (inc_i) begin
                        if (st_q.lo[LW-1:0] == '1) begin
                            st_d.lo[LW-1:0] = '0;
                            st_d.hi         = st_q.hi + B_ONE;
                            ovf_o           = (st_q.hi == '1);
                        end else begin
                            st_d.lo[LW-1:0] = st_q.lo[LW-1:0] + L_ONE;
                        end
                    end
                end
                MODE_16B: begin
                    if (inc_i) begin
                        {st_d.hi, st_d.lo} = cat_sum;
                        ovf_o = ({st_q.hi, st_q.lo} == '1);
                    end
                end
                MODE_RELOAD: begin
                    if (inc_i) begin
                        if (st_q.lo == '1) begin
                            st_d.lo = st_q.hi;
                            ovf_o   = 1'b1;
                        end else begin
                            st_d.lo = st_q.lo + B_ONE;
                        end
                    end
                end
                MODE_SPLIT: begin
                    if (SPLIT_OK) begin
                        if (inc_i) begin
                            st_d.lo = st_q.lo + B_ONE;
                            ovf_o   = (st_q.lo == '1);
                        end
                        if (inc_hi_i) begin
                            st_d.hi  = st_q.hi + B_ONE;
                            ovf_hi_o = (st_q.hi == '1);
                        end
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_o = st_q.lo;
    assign hi_o = st_q.hi;

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_RELOAD && inc_i && st_q.lo == '1 && !wr_lo_i && !wr_hi_i)
        |=> (st_q.lo == $past(st_q.hi)) && (st_q.hi == $past(st_q.hi)));

    // R4
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_13B && !wr_lo_i)
        |=> st_q.lo[DW-1:LW] == $past(st_q.lo[DW-1:LW]));

    // R2
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_i |=> st_q.lo == $past(wdata_i));

    // R12
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !inc_hi_i && !wr_lo_i && !wr_hi_i) |=> st_q == $past(st_q));

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pair_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int LW = LOW13_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [1:0]    cnt_pin_i,
    input  logic [1:0]    gate_pin_i,
    input  logic [1:0]    ack_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    output logic [1:0]    ovf_flag_o
);

    localparam int NCH = 2;

    typedef struct packed {
        logic [4*NCH-1:0] cfg;
        logic [NCH-1:0]   run;
        logic [NCH-1:0]   flag;
    } regs_t;

    regs_t st_d, st_q;

    chcfg_t          cfg     [NCH];
    logic [NCH-1:0]  fall;
    logic [NCH-1:0]  inc, inc_hi, wr_lo, wr_hi, ovf, ovf_hi, set;
    logic [DW-1:0]   lo_w    [NCH];
    logic [DW-1:0]   hi_w    [NCH];
    logic            wr_ctrl, split0;

    tmr_edge_smp #(.N(NCH)) u_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .pin_i  (cnt_pin_i),
        .fall_o (fall)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign cfg[g] = chcfg_t'(st_q.cfg[4*g +: 4]);

        tmr_chan #(.DW(DW), .LW(LW), .SPLIT_OK(g == 0)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_i   (cfg[g].mode),
            .inc_i    (inc[g]),
            .inc_hi_i (inc_hi[g]),
            .wr_lo_i  (wr_lo[g]),
            .wr_hi_i  (wr_hi[g]),
            .wdata_i  (wr_data_i),
            .lo_o     (lo_w[g]),
            .hi_o     (hi_w[g]),
            .ovf_o    (ovf[g]),
            .ovf_hi_o (ovf_hi[g])
        );
    end

    // counting enables and register decode
    always_comb begin
        split0  = (cfg[0].mode == MODE_SPLIT);
        wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
        for (int i = 0; i < NCH; i++) begin
            wr_lo[i] = wr_en_i && (wr_addr_i == A_CNT0 + AW'(2 * i));
            wr_hi[i] = wr_en_i && (wr_addr_i == A_CNT0 + AW'(2 * i + 1));
            inc[i]   = st_q.run[i] && (!cfg[i].gate || gate_pin_i[i])
                       && (cfg[i].ext ? fall[i] : tick_i);
            inc_hi[i] = 1'b0;
        end
        inc_hi[0] = split0 && st_q.run[1] && tick_i;
        if (cfg[1].mode == MODE_SPLIT) inc[1] = 1'b0;
        set[0] = ovf[0];
        set[1] = (split0 ? ovf_hi[0] : ovf[1]) | ovf_hi[1];
    end

    // next register state
    always_comb begin
        st_d      = st_q;
        st_d.flag = (st_q.flag & ~ack_i) | set;
        if (wr_en_i && wr_addr_i == A_CFG) st_d.cfg = wr_data_i;
        if (wr_ctrl) begin
            st_d.flag = {wr_data_i[DW-1], wr_data_i[DW-3]};
            st_d.run  = {wr_data_i[DW-2], wr_data_i[DW-4]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (rd_addr_i)
            A_CFG:           rd_data_o = st_q.cfg;
            A_CTRL:          rd_data_o = {st_q.flag[1], st_q.run[1], st_q.flag[0],
                                          st_q.run[0], {(DW-4){1'b0}}};
            A_CNT0:          rd_data_o = lo_w[0];
            A_CNT0 + AW'(1): rd_data_o = hi_w[0];
            A_CNT0 + AW'(2): rd_data_o = lo_w[1];
            A_CNT0 + AW'(3): rd_data_o = hi_w[1];
            default:         rd_data_o = '0;
        endcase
    end

    assign ovf_flag_o = st_q.flag;

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag[0] && !ack_i[0] && !wr_ctrl) |=> st_q.flag[0]);

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set[0] && !wr_ctrl) |=> st_q.flag[0]);

    // R11
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i[1] && !set[1] && !wr_ctrl) |=> !st_q.flag[1]);

    // R7
    ch1_split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[1].mode == MODE_SPLIT && !wr_lo[1] && !wr_hi[1])
        |=> (lo_w[1] == $past(lo_w[1])) && (hi_w[1] == $past(hi_w[1])));

    // R8
    gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[0].gate && !gate_pin_i[0] && cfg[0].mode == MODE_16B
         && !wr_lo[0] && !wr_hi[0])
        |=> (lo_w[0] == $past(lo_w[0])) && (hi_w[0] == $past(hi_w[0])));

endmodule

// File: tb/tmr_pair_test.sv
`timescale 1ns/1ps
module tmr_pair_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [1:0] cnt_pin_i = 2'b00;
    logic [1:0] gate_pin_i = 2'b00;
    logic [1:0] ack_i = 2'b00;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [2:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic [1:0] ovf_flag_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tmr_pair uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_pin_i(cnt_pin_i),
        .gate_pin_i(gate_pin_i), .ack_i(ack_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .ovf_flag_o(ovf_flag_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr_i = a;
        #1;
        d = rd_data_o;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic rd16(input logic [2:0] lo_a, output logic [15:0] v);
        logic [7:0] l, h;
        rd(lo_a, l);
        rd(lo_a + 3'd1, h);
        v = {h, l};
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 reset reg", {8'h0, d}, 16'h0000);
        end
        chk("R1 reset flags", {14'h0, ovf_flag_o}, 16'h0000);
    endtask

    task automatic t_regs;
        logic [7:0] d;
        wr(3'd0, 8'hA5);
        rd(3'd0, d);
        chk("R2 cfg readback", {8'h0, d}, 16'h00A5);
        wr(3'd1, 8'hFF);
        rd(3'd1, d);
        chk("R2 ctrl low bits zero", {8'h0, d}, 16'h00F0);
        chk("R2 ctrl flag write", {14'h0, ovf_flag_o}, 16'h0003);
        rd(3'd6, d);
        chk("R2 unmapped", {8'h0, d}, 16'h0000);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_run_off;
        logic [15:0] v;
        wr(3'd0, 8'h01);
        wr(3'd2, 8'h07); wr(3'd3, 8'h00);
        ticks(10);
        rd16(3'd2, v);
        chk("R12 run off holds", v, 16'h0007);
    endtask

    task automatic t_16b;
        logic [15:0] v;
        logic [7:0] d;
        wr(3'd0, 8'h01);
        wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
        wr(3'd1, 8'h10);
        ticks(1);
        rd16(3'd2, v);
        chk("R5 16b count", v, 16'hFFFF);
        chk("R10 no early flag", {14'h0, ovf_flag_o}, 16'h0000);
        ticks(1);
        rd16(3'd2, v);
        chk("R5 16b rollover", v, 16'h0000);
        chk("R10 flag0 set", {14'h0, ovf_flag_o}, 16'h0001);
        rd(3'd1, d);
        chk("R10 ctrl shows flag0", {8'h0, d}, 16'h0030);
        ticks(3);
        chk("R10 flag0 stays", {14'h0, ovf_flag_o}, 16'h0001);
        @(negedge clk); ack_i = 2'b01;
        @(negedge clk); ack_i = 2'b00;
        chk("R11 ack clears", {14'h0, ovf_flag_o}, 16'h0000);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_13b;
        logic [15:0] v;
        wr(3'd0, 8'h00);
        wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
        wr(3'd1, 8'h40);
        ticks(1);
        rd16(3'd4, v);
        chk("R4 13b low count", v, 16'hFFFF);
        chk("R4 no flag yet", {14'h0, ovf_flag_o}, 16'h0000);
        ticks(1);
        rd16(3'd4, v);
        chk("R4 13b rollover keeps upper low bits", v, 16'h00E0);
        chk("R4 flag1 set", {14'h0, ovf_flag_o}, 16'h0002);
        wr(3'd4, 8'h1F); wr(3'd5, 8'h12);
        wr(3'd1, 8'h40);
        ticks(1);
        rd16(3'd4, v);
        chk("R4 carry into high", v, 16'h1300);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_reload;
        logic [15:0] v;
        wr(3'd0, 8'h02);
        wr(3'd2, 8'hFE); wr(3'd3, 8'h80);
        wr(3'd1, 8'h10);
        ticks(2);
        rd16(3'd2, v);
        chk("R6 reload from high", v, 16'h8080);
        chk("R6 flag0 on reload", {14'h0, ovf_flag_o}, 16'h0001);
        ticks(1);
        rd16(3'd2, v);
        chk("R6 count after reload", v, 16'h8081);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_split;
        logic [15:0] v;
        wr(3'd0, 8'h33);
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        wr(3'd4, 8'h12); wr(3'd5, 8'h34);
        wr(3'd1, 8'h50);
        ticks(1);
        rd16(3'd2, v);
        chk("R7 both halves roll", v, 16'h0000);
        chk("R7 both flags", {14'h0, ovf_flag_o}, 16'h0003);
        rd16(3'd4, v);
        chk("R7 ch1 split holds", v, 16'h3412);
        wr(3'd1, 8'h40);
        ticks(2);
        rd16(3'd2, v);
        chk("R7 high half on run1 only", v, 16'h0200);
        // channel 1 counting while channel 0 split: its overflow must not set flag1
        wr(3'd0, 8'h13);
        wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
        wr(3'd3, 8'h10);
        ticks(1);
        rd16(3'd4, v);
        chk("R7 ch1 counts while ch0 split", v, 16'h0000);
        chk("R7 ch1 overflow masked", {14'h0, ovf_flag_o}, 16'h0000);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_gate;
        logic [15:0] v;
        wr(3'd0, 8'h09);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd1, 8'h10);
        gate_pin_i = 2'b00;
        ticks(3);
        rd16(3'd2, v);
        chk("R8 R3 gate low blocks", v, 16'h0000);
        gate_pin_i = 2'b01;
        ticks(3);
        rd16(3'd2, v);
        chk("R8 gate high counts", v, 16'h0003);
        gate_pin_i = 2'b00;
        wr(3'd0, 8'h01);
        ticks(2);
        rd16(3'd2, v);
        chk("R8 gate off ignores pin", v, 16'h0005);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_ext;
        logic [15:0] v;
        wr(3'd0, 8'h50);
        wr(3'd4, 8'h00); wr(3'd5, 8'h00);
        wr(3'd1, 8'h40);
        cnt_pin_i = 2'b10; ticks(1);
        cnt_pin_i = 2'b00; ticks(1);
        rd16(3'd4, v);
        chk("R9 R3 one fall one count", v, 16'h0001);
        ticks(2);
        rd16(3'd4, v);
        chk("R9 steady low no count", v, 16'h0001);
        @(negedge clk); cnt_pin_i = 2'b10;
        repeat (3) @(negedge clk);
        cnt_pin_i = 2'b00;
        repeat (3) @(negedge clk);
        ticks(1);
        rd16(3'd4, v);
        chk("R9 pulse between ticks unseen", v, 16'h0001);
        cnt_pin_i = 2'b10; ticks(1);
        cnt_pin_i = 2'b00; ticks(1);
        rd16(3'd4, v);
        chk("R9 second fall", v, 16'h0002);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_wr_prio;
        logic [15:0] v;
        wr(3'd0, 8'h01);
        wr(3'd2, 8'h10); wr(3'd3, 8'h22);
        wr(3'd1, 8'h10);
        @(negedge clk);
        tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 3'd2; wr_data_i = 8'h55;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        rd16(3'd2, v);
        chk("R2 write beats count", v, 16'h2255);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_flag_prio;
        logic [15:0] v;
        wr(3'd0, 8'h01);
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        wr(3'd1, 8'h30);
        @(negedge clk); tick_i = 1'b1; ack_i = 2'b01;
        @(negedge clk); tick_i = 1'b0; ack_i = 2'b00;
        rd16(3'd2, v);
        chk("R11 rollover with ack", v, 16'h0000);
        chk("R11 set beats ack", {14'h0, ovf_flag_o}, 16'h0001);
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        @(negedge clk);
        tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 3'd1; wr_data_i = 8'h10;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        chk("R11 ctrl write beats overflow", {14'h0, ovf_flag_o}, 16'h0000);
        wr(3'd1, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_run_off();
        t_16b();
        t_13b();
        t_reload();
        t_split();
        t_gate();
        t_ext();
        t_wr_prio();
        t_flag_prio();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule